// File: doc/BRIEF.md
# Voltage Detect Interrupt Controller

This block is the digital side of a supply-voltage monitor. An analog comparator outside the block compares the supply against one of sixteen thresholds. The block picks the threshold, decides whether a rise or a fall is the event of interest, and raises an interrupt when that event is seen. Software reaches the block through a small byte-wide register port. The port has three registers: control, status and interrupt enable.

The analog reference needs time to settle after it is switched on. The block therefore runs a start-up timer after every enable. The timer counts pulses of a separate slow timebase, so the interval does not depend on the core clock. Until the timer expires, the reference-ready status stays low and the event flag cannot set.

Once the reference is ready, the synchronized comparator result is checked against the chosen direction on every clock. Software clears the flag by writing zero to it. If the voltage is still on the wrong side of the threshold, the flag sets again at once.

Top module: `vdet_irq_ctrl`

## Requirements
- R1: The control register is at address 0. Bit 4 is the enable, bits 3:0 are the threshold select, and bit 7 is the direction. Output `det_en` follows bit 4.
- R2: Output `trip_sel` equals control bits 3:0 and changes only on a write to address 0.
- R3: `cmp_above` passes through two flip-flops before it can set the flag. If the input enters the selected condition just after clock edge k, the flag reads 1 after edge k+3 and 0 after edges k+1 and k+2.
- R4: The status register is at address 1, and its bit 1 is reference-ready. Reference-ready goes to 1 once `slow_tick` has been high on `STARTUP_TICKS` clock edges while enabled. Clock edges without a tick do not advance it.
- R5: The flag (status bit 0) never sets while reference-ready is 0. A condition that ends before reference-ready goes high is missed.
- R6: When direction is 1, the flag sets while `cmp_above` is 1, which means the supply is above the threshold. When direction is 0, the flag sets while `cmp_above` is 0.
- R7: The interrupt-enable register is at address 2. Bit 0 is the local enable and bit 1 is the global enable. `irq` is 1 exactly when the flag, the local enable and the global enable are all 1.
- R8: While the enable bit is 0, reference-ready is 0 and the tick count is reset. Every re-enable waits the full interval again.
- R9: Writing 0 to status bit 0 clears the flag, unless the selected condition holds in that cycle; the condition wins. Writing 1 to status bit 0 has no effect. The flag keeps its value across a disable.
- R10: After reset every register reads 0. Control bits 6:5, status bits 7:2, interrupt-enable bits 7:2 and all of address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cmp_above | input | 1 | Comparator result: 1 when the supply is above the threshold |
| slow_tick | input | 1 | Single-cycle pulse from the slow start-up timebase |
| det_en | output | 1 | Enable for the analog comparator and divider |
| trip_sel | output | 4 | Threshold select for the analog divider |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear that lands while the voltage condition still holds. Here the set and the clear meet in one cycle, and the flag must stay high. The stimulus gets there by holding the comparator in the selected state, waiting out the start-up interval, and then writing zero to the flag.

Missed crossings need the comparator to sit in the condition while the reference is still settling. The bench stops the slow timebase for many clock cycles to show that clock cycles alone never end the interval. A disable/re-enable pair then restarts the full count.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int TRIP_W = 4;
    localparam int CNT_W  = 8;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [AW-1:0] ADDR_IEN  = 2'd2;

    localparam int CTRL_EN_BIT  = 4;
    localparam int CTRL_DIR_BIT = 7;
    localparam int STAT_FLG_BIT = 0;
    localparam int STAT_RDY_BIT = 1;
    localparam int IEN_LOC_BIT  = 0;
    localparam int IEN_GLB_BIT  = 1;

    localparam logic [DW-1:0] WR_MASK = 8'h9F;

    typedef struct packed {
        logic              en;
        logic              dir;
        logic [TRIP_W-1:0] trip;
        logic              flag;
        logic              loc_ie;
        logic              glb_ie;
    } vdet_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } vdet_tmr_t;
endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vdet_startup.sv
module vdet_startup
    import vdet_pkg::*;
#(
    parameter int TERM = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic ready
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

    vdet_tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!en) begin
            tmr_d.cnt   = '0;
            tmr_d.ready = 1'b0;
        end else if (!tmr_q.ready && tick) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt   = '0;
                tmr_d.ready = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign ready = tmr_q.ready;
endmodule

// File: rtl/vdet_irq_ctrl.sv
module vdet_irq_ctrl
    import vdet_pkg::*;
#(
    parameter int STARTUP_TICKS = 200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              cmp_above,
    input  logic              slow_tick,
    output logic              det_en,
    output logic [TRIP_W-1:0] trip_sel,
    output logic              irq
);
    vdet_regs_t    regs_d, regs_q;
    logic          cmp_s;
    logic          ref_ready;
    logic          cond_hit;
    logic          flag_now;
    logic [DW-1:0] wbyte;

    vdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_above),
        .q     (cmp_s)
    );

    vdet_startup #(.TERM(STARTUP_TICKS)) u_startup (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (regs_q.en),
        .tick  (slow_tick),
        .ready (ref_ready)
    );

    always_comb begin
        regs_d   = regs_q;
        wbyte    = reg_wdata & WR_MASK;
        cond_hit = regs_q.en & ref_ready & (regs_q.dir ? cmp_s : ~cmp_s);

        if (reg_wr && reg_addr == ADDR_CTRL) begin
            regs_d.en   = wbyte[CTRL_EN_BIT];
            regs_d.dir  = wbyte[CTRL_DIR_BIT];
            regs_d.trip = wbyte[TRIP_W-1:0];
        end
        if (reg_wr && reg_addr == ADDR_IEN) begin
            regs_d.loc_ie = wbyte[IEN_LOC_BIT];
            regs_d.glb_ie = wbyte[IEN_GLB_BIT];
        end
        if (cond_hit) begin
            regs_d.flag = 1'b1;
        end else if (reg_wr && reg_addr == ADDR_STAT && !wbyte[STAT_FLG_BIT]) begin
            regs_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN_BIT]  = regs_q.en;
                reg_rdata[CTRL_DIR_BIT] = regs_q.dir;
                reg_rdata[TRIP_W-1:0]   = regs_q.trip;
            end
            ADDR_STAT: begin
                reg_rdata[STAT_FLG_BIT] = regs_q.flag;
                reg_rdata[STAT_RDY_BIT] = ref_ready;
            end
            ADDR_IEN: begin
                reg_rdata[IEN_LOC_BIT] = regs_q.loc_ie;
                reg_rdata[IEN_GLB_BIT] = regs_q.glb_ie;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign flag_now = regs_q.flag;
    assign det_en   = regs_q.en;
    assign trip_sel = regs_q.trip;
    assign irq      = flag_now & regs_q.loc_ie & regs_q.glb_ie;
endmodule

// File: rtl/vdet_irq_ctrl_chk.sv
module vdet_irq_ctrl_chk
    import vdet_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic              det_en,
    input logic [TRIP_W-1:0] trip_sel,
    input logic              irq,
    input logic              flag,
    input logic              ready
);
    AST_FLAG_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ready)); // R5

    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_CTRL) |=> $stable(trip_sel)); // R2

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R7

    AST_NOT_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !ready); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr == ADDR_STAT)) |=> flag); // R9
endmodule

bind vdet_irq_ctrl vdet_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .det_en   (det_en),
    .trip_sel (trip_sel),
    .irq      (irq),
    .flag     (flag_now),
    .ready    (ref_ready)
);

// File: tb/vdet_irq_ctrl_test.sv
module vdet_irq_ctrl_test;
    localparam int TC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cmp_above = 1'b1;
    logic       slow_tick = 1'b0;
    logic       det_en;
    logic [3:0] trip_sel;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit tick_on = 1'b0;

    // behavioural reference state
    int m_en, m_dir, m_trip, m_flag, m_lie, m_gie, m_rdy, m_ticks;
    bit pipe[$];

    always #5 clk = ~clk;

    vdet_irq_ctrl #(.STARTUP_TICKS(TC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_above(cmp_above),
        .slow_tick(slow_tick), .det_en(det_en), .trip_sel(trip_sel), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_dir = 0; m_trip = 0; m_flag = 0;
            m_lie = 0; m_gie = 0; m_rdy = 0; m_ticks = 0;
            pipe = '{1'b0, 1'b0};
        end else begin
            int hit;
            int n_flag, n_rdy, n_ticks;
            hit = (m_en && m_rdy && (m_dir ? pipe[0] : !pipe[0])) ? 1 : 0;
            n_flag = m_flag; n_rdy = m_rdy; n_ticks = m_ticks;
            if (hit) n_flag = 1;
            else if (reg_wr && reg_addr == 2'd1 && !reg_wdata[0]) n_flag = 0;
            if (!m_en) begin
                n_rdy = 0; n_ticks = 0;
            end else if (!m_rdy && slow_tick) begin
                n_ticks = n_ticks + 1;
                if (n_ticks == TC) begin n_rdy = 1; n_ticks = 0; end
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_en = reg_wdata[4]; m_dir = reg_wdata[7]; m_trip = int'(reg_wdata[3:0]);
            end
            if (reg_wr && reg_addr == 2'd2) begin
                m_lie = reg_wdata[0]; m_gie = reg_wdata[1];
            end
            m_flag = n_flag; m_rdy = n_rdy; m_ticks = n_ticks;
            void'(pipe.pop_front());
            pipe.push_back(cmp_above);
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_dir * 128 + m_en * 16 + m_trip;
            1: return m_rdy * 2 + m_flag;
            2: return m_gie * 2 + m_lie;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // one clock: compare at the falling edge, then drive the next inputs
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk("R7 irq", int'(irq), m_lie & m_gie & m_flag);
            chk("R1 det_en", int'(det_en), m_en);
            chk("R2 trip_sel", int'(trip_sel), m_trip);
            chk(reg_addr == 2'd1 ? "R9 status" : "R10 readback", int'(reg_rdata), model_read(int'(reg_addr)));
        end
        reg_wr    = 1'b0;
        slow_tick = tick_on && (cyc % 3 == 0);
        cyc++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        step();
        reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R10: reset state, all addresses zero
        rd(2'd0, 0, "R10 ctrl reset"); rd(2'd1, 0, "R10 stat reset");
        rd(2'd2, 0, "R10 ien reset");  rd(2'd3, 0, "R10 addr3");

        // R1/R2: enable, falling direction, threshold 0xA; comparator low
        cmp_above = 1'b0;
        wr(2'd0, 8'h1A);
        step();
        chk("R2 trip_sel out", int'(trip_sel), 'hA);
        chk("R1 det_en on", int'(det_en), 1);
        rd(2'd0, 'h1A, "R1 ctrl readback");
        wr(2'd0, 8'hFF);
        rd(2'd0, 'h9F, "R10 ctrl unused bits");
        wr(2'd0, 8'h1A);

        // R5: condition present but reference still settling
        tick_on = 1'b1;
        repeat (4) step();
        rd(2'd1, 0, "R5 no flag before ready");
        repeat (20) step();
        rd(2'd1, 3, "R4 ready and flag");

        // R9: clear while condition still holds -> flag stays
        wr(2'd1, 8'h00);
        step();
        rd(2'd1, 3, "R9 set wins over clear");

        // R6: supply above, falling direction -> clear sticks
        cmp_above = 1'b1;
        repeat (4) step();
        wr(2'd1, 8'h00);
        repeat (3) step();
        rd(2'd1, 2, "R6 no flag above with dir 0");
        wr(2'd1, 8'h01);
        rd(2'd1, 2, "R9 write 1 ignored");

        // R3: two synchronizer stages then flag register
        step();
        cmp_above = 1'b0;
        rd(2'd1, 2, "R3 edge 1");
        rd(2'd1, 2, "R3 edge 2");
        rd(2'd1, 3, "R3 edge 3");

        // R6: rising direction
        wr(2'd0, 8'h9A);
        repeat (3) step();
        wr(2'd1, 8'h00);
        repeat (3) step();
        rd(2'd1, 2, "R6 no flag below with dir 1");
        cmp_above = 1'b1;
        repeat (4) step();
        rd(2'd1, 3, "R6 flag above with dir 1");

        // R7: interrupt gating
        wr(2'd2, 8'h01); step(); chk("R7 local only", int'(irq), 0);
        wr(2'd2, 8'h02); step(); chk("R7 global only", int'(irq), 0);
        wr(2'd2, 8'h03); step(); chk("R7 both", int'(irq), 1);
        rd(2'd2, 3, "R7 ien readback");
        cmp_above = 1'b0;
        repeat (3) step();
        wr(2'd1, 8'h00);
        step(); step();
        chk("R7 flag cleared", int'(irq), 0);

        // R8: disable drops ready; re-enable waits again; ticks only count
        wr(2'd0, 8'h8A);
        step();
        rd(2'd1, 0, "R8 ready cleared");
        chk("R8 det_en off", int'(det_en), 0);
        tick_on = 1'b0;
        wr(2'd0, 8'h9A);
        repeat (40) step();
        rd(2'd1, 0, "R4 no ticks no ready");
        tick_on = 1'b1;
        repeat (6) step();
        rd(2'd1, 0, "R8 full wait after re-enable");
        repeat (20) step();
        rd(2'd1, 2, "R4 ready after ticks");

        repeat (3) step();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule